// File: doc/BRIEF.md
# Autonomous Drum Step Sequencer with MIDI Serial Output

This block plays an eight-track, sixteen-step drum pattern by itself. A host processor loads a step mask and a note number for every track, plus a tempo expressed as system clocks per step, through a small write port. Once the host sets the enable bit, a step timer advances the pattern one sixteenth note at a time. At each step the block emits MIDI messages on a single serial line. The host takes no part in step timing.

At every step boundary the block first releases the notes that sounded on the previous step, then triggers the notes of the current step. A release is a Note On with velocity zero. Internally, a message assembler hands bytes one at a time to the serial transmitter over a valid/ready pair. While ready is low, the assembler holds the offered byte unchanged. The transmitter accepts a new byte only after its current frame has ended. A step boundary never cuts a burst short. It waits until the assembler and the transmitter are both empty, so that no step is ever skipped.

Top module: `step_sequencer`

## Requirements
- R1: After reset the serial line is high, and the status register reads step 0 with the busy flag clear. Whenever busy reads 0, the line is high.
- R2: Each byte goes out as one frame. The frame has a low start bit, then 8 data bits least significant bit first, then a high stop bit. Every bit lasts CLK_HZ/BAUD clocks. The line falls to the start bit in the cycle after the transmitter accepts a byte.
- R3: While no messages are pending, the status step index changes exactly every tempo clocks. The index advances by one, and after step 15 it returns to step 0. Enabling the block plays step 0 first.
- R4: A tempo value of 0 behaves as 1. A tempo write does not change the step interval already in progress. The new value applies from the next boundary.
- R5: For each track whose mask bit s is set (bit s = step s), step s emits bytes 0x99, then the 7-bit note, then 0x64. Tracks are handled in ascending order, 0 to 7.
- R6: Before the Note On messages of a step, each note triggered on the previous step is released with 0x99, its note, 0x00. Releases go in ascending track order and use the note number in force when that note was triggered.
- R7: If a step's messages are still in flight when the tempo interval expires, the boundary waits for the transmitter to drain. The step index still advances by exactly one.
- R8: Clearing the enable bit sets the step index to 0 at once. It lets the message already being sent finish, drops Note On messages not yet begun, and then releases every sounding note.
- R9: Register map: 0x00+t writes the step mask of track t, 0x08+t writes the note of track t (bits 6:0), 0x10 writes the tempo (bits 23:0), and 0x11 bit 0 is enable. Reading 0x12 returns the step index in bits 7:0 and busy in bit 8. Busy is set while any message is pending or being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 32 | Read data; status at 0x12, zero elsewhere |
| midi_out | output | 1 | Serial MIDI line, idle high |

## Verification
The hardest case to reach is a disable that arrives while a Note On is halfway out and a second Note On for the same step is still queued. The bench reaches it by arming two tracks on step 0 only, with a very long tempo. It drops enable ten clocks after playback starts, which falls inside the first byte of the first message. The expected stream is then the complete first Note On and its release, with no trace of the second track. A separate run uses a tempo far shorter than one message burst, to force delayed boundaries. Another writes a note number while that track is sounding, to show that the release carries the note that was triggered.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  localparam logic [4:0] A_PAT   = 5'h00;
  localparam logic [4:0] A_NOTE  = 5'h08;
  localparam logic [4:0] A_TEMPO = 5'h10;
  localparam logic [4:0] A_CTRL  = 5'h11;
  localparam logic [4:0] A_STAT  = 5'h12;

  localparam logic [7:0] MSG_STATUS = 8'h99;
  localparam logic [7:0] VEL_HIT    = 8'h64;
  localparam logic [7:0] VEL_REL    = 8'h00;

  typedef logic [6:0] note_t;
endpackage

// File: rtl/seqr_step_clock.sv
module seqr_step_clock #(
  parameter int TEMPO_W = 24,
  parameter int N_STEPS = 16,
  parameter int STEP_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               idle,
  input  logic [TEMPO_W-1:0] tempo,
  output logic               fire,
  output logic [STEP_W-1:0]  step,
  output logic [STEP_W-1:0]  nxt_step
);
  logic [TEMPO_W-1:0] cnt;
  logic [TEMPO_W-1:0] period;
  logic               started;

  // first boundary after enable plays step 0
  assign nxt_step = !started ? '0 :
                    (step == STEP_W'(N_STEPS - 1)) ? '0 : step + 1'b1;

  // a boundary needs the interval expired and every message drained
  assign fire = en && idle && (!started || cnt >= period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      period  <= TEMPO_W'(1);
      started <= 1'b0;
      step    <= '0;
    end else if (!en) begin
      cnt     <= '0;
      started <= 1'b0;
      step    <= '0;
    end else if (fire) begin
      cnt     <= TEMPO_W'(1);
      period  <= (tempo == '0) ? TEMPO_W'(1) : tempo;
      step    <= nxt_step;
      started <= 1'b1;
    end else if (cnt < period) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/seqr_msg_engine.sv
module seqr_msg_engine
  import seqr_pkg::*;
#(
  parameter int N_TRACKS = 8,
  parameter int TRK_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic                      fire,
  input  logic [N_TRACKS-1:0]       column,
  input  logic [N_TRACKS-1:0][6:0]  notes,
  output logic                      b_valid,
  output logic [7:0]                b_data,
  input  logic                      b_ready,
  output logic                      idle
);
  logic [N_TRACKS-1:0]      on_mask, rel_mask, sounding;
  logic [N_TRACKS-1:0][6:0] on_note, rel_note, snd_note;
  logic                     msg_active, msg_rel;
  logic [1:0]               bidx;
  note_t                    msg_note;

  logic             have_sel, sel_rel;
  logic [TRK_W-1:0] sel_idx;
  logic             commit;

  // releases outrank note-ons; lowest track first within each kind
  always_comb begin
    have_sel = 1'b0;
    sel_rel  = 1'b0;
    sel_idx  = '0;
    for (int i = N_TRACKS - 1; i >= 0; i--) begin
      if (en && on_mask[i]) begin
        have_sel = 1'b1;
        sel_rel  = 1'b0;
        sel_idx  = TRK_W'(i);
      end
    end
    for (int i = N_TRACKS - 1; i >= 0; i--) begin
      if (rel_mask[i]) begin
        have_sel = 1'b1;
        sel_rel  = 1'b1;
        sel_idx  = TRK_W'(i);
      end
    end
  end

  assign idle    = !msg_active && (rel_mask == '0) && (on_mask == '0);
  assign commit  = !msg_active && have_sel;
  assign b_valid = msg_active;

  always_comb begin
    case (bidx)
      2'd0:    b_data = MSG_STATUS;
      2'd1:    b_data = {1'b0, msg_note};
      default: b_data = msg_rel ? VEL_REL : VEL_HIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_mask    <= '0;
      rel_mask   <= '0;
      sounding   <= '0;
      on_note    <= '0;
      rel_note   <= '0;
      snd_note   <= '0;
      msg_active <= 1'b0;
      msg_rel    <= 1'b0;
      bidx       <= '0;
      msg_note   <= '0;
    end else begin
      if (fire) begin
        rel_mask <= sounding;
        rel_note <= snd_note;
        on_mask  <= column;
        on_note  <= notes;
      end
      if (commit) begin
        msg_active <= 1'b1;
        bidx       <= '0;
        msg_rel    <= sel_rel;
        if (sel_rel) begin
          rel_mask[sel_idx] <= 1'b0;
          sounding[sel_idx] <= 1'b0;
          msg_note          <= rel_note[sel_idx];
        end else begin
          on_mask[sel_idx]  <= 1'b0;
          sounding[sel_idx] <= 1'b1;
          snd_note[sel_idx] <= on_note[sel_idx];
          msg_note          <= on_note[sel_idx];
        end
      end else if (msg_active && b_ready) begin
        if (bidx == 2'd2) msg_active <= 1'b0;
        else              bidx       <= bidx + 2'd1;
      end
      // stopping: drop unstarted hits, then release whatever still sounds
      if (!en) begin
        on_mask <= '0;
        if (idle && sounding != '0) begin
          rel_mask <= sounding;
          rel_note <= snd_note;
        end
      end
    end
  end
endmodule

// File: rtl/seqr_midi_tx.sv
module seqr_midi_tx #(
  parameter int DIV = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       line,
  output logic       active
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [8:0]    shreg;
  logic [3:0]    nbits;
  logic [CW-1:0] divcnt;

  assign in_ready = !active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      line   <= 1'b1;
      shreg  <= '0;
      nbits  <= '0;
      divcnt <= '0;
    end else if (!active) begin
      if (in_valid) begin
        active <= 1'b1;
        line   <= 1'b0;
        shreg  <= {1'b1, in_data};
        nbits  <= 4'd9;
        divcnt <= CW'(DIV - 1);
      end
    end else if (divcnt == '0) begin
      if (nbits == 4'd0) begin
        active <= 1'b0;
      end else begin
        line   <= shreg[0];
        shreg  <= {1'b0, shreg[8:1]};
        nbits  <= nbits - 4'd1;
        divcnt <= CW'(DIV - 1);
      end
    end else begin
      divcnt <= divcnt - 1'b1;
    end
  end
endmodule

// File: rtl/step_sequencer.sv
module step_sequencer
  import seqr_pkg::*;
#(
  parameter int CLK_HZ   = 125_000_000,
  parameter int BAUD     = 31250,
  parameter int N_TRACKS = 8,
  parameter int N_STEPS  = 16,
  parameter int TEMPO_W  = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        midi_out
);
  localparam int STEP_W = $clog2(N_STEPS);
  localparam int TRK_W  = $clog2(N_TRACKS);
  localparam int DIV    = CLK_HZ / BAUD;

  logic [N_TRACKS-1:0][N_STEPS-1:0] pat;
  logic [N_TRACKS-1:0][6:0]         note;
  logic [TEMPO_W-1:0]               tempo;
  logic                             en_q;

  logic              fire, eng_idle, tx_active, busy;
  logic [STEP_W-1:0] step, nxt_step;
  logic [N_TRACKS-1:0] column;
  logic              b_valid, b_ready;
  logic [7:0]        b_data;
  logic              unused_wr;

  assign unused_wr = ^wr_data[31:TEMPO_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat   <= '0;
      note  <= '0;
      tempo <= TEMPO_W'(1);
      en_q  <= 1'b0;
    end else if (wr_en) begin
      for (int t = 0; t < N_TRACKS; t++) begin
        if (wr_addr == A_PAT + 5'(t))  pat[t]  <= wr_data[N_STEPS-1:0];
        if (wr_addr == A_NOTE + 5'(t)) note[t] <= wr_data[6:0];
      end
      if (wr_addr == A_TEMPO) tempo <= wr_data[TEMPO_W-1:0];
      if (wr_addr == A_CTRL)  en_q  <= wr_data[0];
    end
  end

  always_comb begin
    for (int t = 0; t < N_TRACKS; t++) column[t] = pat[t][nxt_step];
  end

  assign busy = !(eng_idle && !tx_active);

  seqr_step_clock #(.TEMPO_W(TEMPO_W), .N_STEPS(N_STEPS), .STEP_W(STEP_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .en(en_q), .idle(!busy), .tempo(tempo),
    .fire(fire), .step(step), .nxt_step(nxt_step)
  );

  seqr_msg_engine #(.N_TRACKS(N_TRACKS), .TRK_W(TRK_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .en(en_q), .fire(fire), .column(column),
    .notes(note), .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
    .idle(eng_idle)
  );

  seqr_midi_tx #(.DIV(DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_data(b_data),
    .in_ready(b_ready), .line(midi_out), .active(tx_active)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_STAT) begin
      rd_data[7:0] = 8'(step);
      rd_data[8]   = busy;
    end
  end
endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [STEP_W-1:0] step,
  input logic              busy,
  input logic              line,
  input logic              tx_active,
  input logic              b_valid,
  input logic              b_ready,
  input logic [7:0]        b_data
);
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready) |=> !line);

  assert_byte_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_data)));

  assert_step_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(step) |-> (step == STEP_W'($past(step) + 1'b1)) || (step == '0));

  assert_boundary_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(step) && step != '0) |-> !$past(tx_active));

  assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (step == '0));
endmodule

bind step_sequencer seqr_checker #(.STEP_W(STEP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .step(step), .busy(busy),
  .line(midi_out), .tx_active(tx_active), .b_valid(b_valid),
  .b_ready(b_ready), .b_data(b_data)
);

// File: tb/sim_step_sequencer.sv
module sim_step_sequencer;
  localparam int CLK_HZ = 250000;
  localparam int BAUD   = 31250;
  localparam int BITC   = CLK_HZ / BAUD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        midi_out;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  int exp_q[$];
  int chg_t[$];
  int chg_s[$];
  int last_step = 0;

  int m_pat[8];
  int m_note[8];
  bit m_snd[8];
  int m_sndn[8];

  step_sequencer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(5'h12), .rd_data(rd_data), .midi_out(midi_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // step index monitor
  always @(negedge clk) begin
    if (rst_n && int'(rd_data[7:0]) != last_step) begin
      last_step = int'(rd_data[7:0]);
      chg_t.push_back(cyc);
      chg_s.push_back(last_step);
    end
  end

  // serial line decoder compared against the reference byte queue
  initial begin
    logic [7:0] b;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (midi_out == 1'b0) begin
        repeat (BITC / 2) @(negedge clk);
        chk(midi_out == 1'b0, "R2", "start bit", midi_out, 0);
        for (int k = 0; k < 8; k++) begin
          repeat (BITC) @(negedge clk);
          b[k] = midi_out;
        end
        repeat (BITC) @(negedge clk);
        chk(midi_out == 1'b1, "R2", "stop bit", midi_out, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 R6", "unexpected byte", int'(b), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(b) == e, "R5 R6", "stream byte", int'(b), e);
        end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_pat(input int t, input int v);
    wr(t, v); m_pat[t] = v;
  endtask

  task automatic set_note(input int t, input int v);
    wr(8 + t, v); m_note[t] = v;
  endtask

  task automatic push_msg(input int n, input int v);
    exp_q.push_back(8'h99); exp_q.push_back(n); exp_q.push_back(v);
  endtask

  task automatic model_step(input int s);
    for (int t = 0; t < 8; t++)
      if (m_snd[t]) begin push_msg(m_sndn[t], 0); m_snd[t] = 0; end
    for (int t = 0; t < 8; t++)
      if (((m_pat[t] >> s) & 1) == 1) begin
        push_msg(m_note[t], 8'h64); m_snd[t] = 1; m_sndn[t] = m_note[t];
      end
  endtask

  task automatic model_off();
    for (int t = 0; t < 8; t++)
      if (m_snd[t]) begin push_msg(m_sndn[t], 0); m_snd[t] = 0; end
  endtask

  task automatic next_change(output int t, output int s);
    while (chg_t.size() == 0) @(negedge clk);
    t = chg_t.pop_front();
    s = chg_s.pop_front();
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (rd_data[8]) @(negedge clk);
  endtask

  task automatic clear_chg();
    chg_t.delete(); chg_s.delete();
  endtask

  initial begin
    int t0, t1, s, ps;
    bit saw_wrap;
    for (int t = 0; t < 8; t++) begin
      m_pat[t] = 0; m_note[t] = 0; m_snd[t] = 0; m_sndn[t] = 0;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(midi_out == 1'b1, "R1", "line after reset", midi_out, 1);
    chk(rd_data[7:0] == 0, "R1", "step after reset", int'(rd_data[7:0]), 0);
    chk(rd_data[8] == 0, "R1", "busy after reset", rd_data[8], 0);

    // R3/R4 timing with an empty pattern
    wr(8'h10, 40);
    wr(8'h11, 1);
    next_change(t0, s);
    chk(s == 1, "R3", "first advance", s, 1);
    next_change(t1, s);
    chk(t1 - t0 == 40, "R3", "step period", t1 - t0, 40);
    chk(s == 2, "R3", "index", s, 2);
    t0 = t1;
    wr(8'h10, 0);
    next_change(t1, s);
    chk(t1 - t0 == 40, "R4", "period kept until boundary", t1 - t0, 40);
    t0 = t1;
    next_change(t1, s);
    chk(t1 - t0 == 1, "R4", "zero tempo as one", t1 - t0, 1);
    ps = s; saw_wrap = 0;
    for (int k = 0; k < 20; k++) begin
      next_change(t1, s);
      if (ps == 15 && s == 0) saw_wrap = 1;
      chk(s == (ps + 1) % 16, "R3", "consecutive index", s, (ps + 1) % 16);
      ps = s;
    end
    chk(saw_wrap, "R3", "wrap 15 to 0", saw_wrap, 1);
    wr(8'h11, 0);
    repeat (3) @(negedge clk);
    chk(rd_data[7:0] == 0, "R8", "step cleared on stop", int'(rd_data[7:0]), 0);
    chk(rd_data[8] == 0, "R9", "busy idle", rd_data[8], 0);
    clear_chg();

    // R5/R6 stream with track order, releases and a note change
    set_pat(0, 16'h1111); set_note(0, 36);
    set_pat(3, 16'hAAAA); set_note(3, 38);
    set_pat(7, 16'h8001); set_note(7, 42);
    wr(8'h10, 1500);
    clear_chg();
    model_step(0);
    wr(8'h11, 1);
    t0 = -1;
    for (int k = 1; k <= 17; k++) begin
      next_change(t1, s);
      chk(s == k % 16, "R3", "pattern step index", s, k % 16);
      if (k >= 2 && k <= 4)
        chk(t1 - t0 == 1500, "R3", "period with traffic", t1 - t0, 1500);
      t0 = t1;
      model_step(s);
      if (k == 1) begin
        wait_idle();
        set_note(3, 40);
      end
    end
    wait_idle();
    wr(8'h11, 0);
    model_off();
    repeat (3) @(negedge clk);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "release on stop drained", exp_q.size(), 0);
    chk(rd_data[7:0] == 0, "R8", "step zero after stop", int'(rd_data[7:0]), 0);
    clear_chg();

    // R7 boundary waits for the transmitter
    set_pat(3, 0); set_pat(7, 0);
    set_pat(0, 16'hFFFF); set_note(0, 50);
    wr(8'h10, 10);
    clear_chg();
    model_step(0);
    wr(8'h11, 1);
    t0 = -1;
    for (int k = 1; k <= 4; k++) begin
      next_change(t1, s);
      chk(s == k, "R7", "no skipped step", s, k);
      if (k >= 2)
        chk(t1 - t0 >= 6 * 10 * BITC, "R7", "delayed boundary", t1 - t0, 6 * 10 * BITC);
      t0 = t1;
      model_step(s);
    end
    set_pat(0, 0);
    next_change(t1, s);
    chk(s == 5, "R7", "index after drain", s, 5);
    model_step(s);
    wait_idle();
    wr(8'h11, 0);
    repeat (3) @(negedge clk);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6", "releases delivered", exp_q.size(), 0);
    clear_chg();

    // R8 stop in the middle of a message, R9 busy flag
    set_pat(1, 1); set_note(1, 60);
    set_pat(5, 1); set_note(5, 64);
    wr(8'h10, 5000);
    push_msg(60, 8'h64);
    push_msg(60, 0);
    wr(8'h11, 1);
    repeat (10) @(negedge clk);
    chk(rd_data[8] == 1, "R9", "busy while sending", rd_data[8], 1);
    wr(8'h11, 0);
    chk(rd_data[7:0] == 0, "R8", "step zero at stop", int'(rd_data[7:0]), 0);
    repeat (3) @(negedge clk);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "message finished and released", exp_q.size(), 0);
    chk(midi_out == 1'b1, "R1", "line idle at end", midi_out, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule